// File: doc/BRIEF.md
# Byte-Bus Capture/Compare Timer

This block is a 16-bit up-counter with two compare channels and one capture channel. A CPU with an 8-bit register bus sets it up and reads it back. Every 16-bit register is reached as a pair of byte addresses. A single holding latch for the upper byte is shared by all four 16-bit registers. Because of that latch, a 16-bit value is always written in one cycle and read as one coherent snapshot.

While the counter runs, it is compared with both compare registers on every clock. On a rising edge of the selected trigger input, the capture register takes the counter value. The trigger is either a pin or a comparator output. The capture register can also act as the counter's wrap point (TOP). Four event flags (overflow, compare A, compare B, capture) are each qualified by a mask bit and a global enable, and together they drive one interrupt request line.

Byte map: 0/1 counter low/high, 2/3 compare A low/high, 4/5 compare B low/high, 6/7 capture low/high, 8 control, 9 mask, 10 flags. Any other address reads as zero.

Top module: `timer16_bytebus`

## Requirements
- R1: After reset, the counter, both compare registers, the capture register, the control byte, the mask and the flags all read zero, and `irq` is low.
- R2: A write to an odd (high) byte address 1, 3, 5 or 7 loads only the shared upper-byte latch. A write to the paired even address commits {latch, written byte} to that 16-bit register in one cycle. The latch is common to all four registers.
- R3: A read of an even (low) byte address returns that register's low byte and copies its high byte into the shared latch. A read of the odd address returns the latch. Addresses above 10 read zero.
- R4: With control bit 0 (run) set, the counter advances by one per clock. With run clear, it holds its value. A low-byte write to the counter takes priority over counting in the same cycle.
- R5: The wrap point is 0xFFFF, or the capture register when control bit 2 is set. When the running counter is at the wrap point, its next value is 0 and flag bit 0 (overflow) is set.
- R6: While running, a counter value equal to compare A sets flag bit 1, and a value equal to compare B sets flag bit 2.
- R7: A rising edge on the selected trigger loads the capture register with the counter value held at that clock edge and sets flag bit 5. Control bit 1 selects the trigger: 0 selects `cap_pin`, 1 selects `cmp_in`. This happens at the first clock edge that sees the trigger high, and it takes priority over a bus write to the capture register.
- R8: Edges on the trigger that is not selected leave the capture register and flag bit 5 unchanged.
- R9: Writing 1 to a flag bit (address 10) clears it, and writing 0 leaves it unchanged. An event that sets a flag in the same cycle as a clear leaves the flag set.
- R10: Mask bits 5, 2, 1 and 0 (address 10 bit meanings) are writable at address 9. All other mask bits read as zero.
- R11: `irq` is high exactly when `glb_ie` is high and some flag bit is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (has latch side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| cap_pin | input | 1 | External capture trigger |
| cmp_in | input | 1 | Comparator output capture trigger |
| glb_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall on the same edge: a flag-setting event and a software clear of that flag, and a low-byte counter read and later counting. The first pair is provoked by loading the counter with the compare A value and then issuing the flag clear on the first running cycle, so the match and the clear share one edge. The bench then expects the flag to read back as set. The second pair is provoked by reading the low byte while the counter is just below a 256 boundary and reading the high byte many cycles later. The stale high byte must match the value at the low-byte read, not the current count.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int ADDR_W  = 4;
    localparam int N_WORDS = 4;
    localparam int N_CMP   = 2;

    // word slots inside the byte map (slot k occupies bytes 2k and 2k+1)
    localparam int SLOT_CNT = 0;
    localparam int SLOT_CMP = 1;
    localparam int SLOT_CAP = 3;

    // flag / mask bit positions
    localparam int FB_OVF  = 0;
    localparam int FB_CMPA = 1;
    localparam int FB_CMPB = 2;
    localparam int FB_CAP  = 5;

    localparam logic [BYTE_W-1:0] FLAG_BITS = 8'h27;

    typedef struct packed {
        logic top_cap;
        logic src_cmp;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        return {{(BYTE_W-CTRL_W){1'b0}}, c};
    endfunction

    function automatic ctrl_t byte_to_ctrl(input logic [BYTE_W-1:0] b);
        return ctrl_t'(b[CTRL_W-1:0]);
    endfunction

endpackage

// File: rtl/tmr16_bus.sv
module tmr16_bus #(
    parameter int BW = tmr16_pkg::BYTE_W,
    parameter int AW = tmr16_pkg::ADDR_W,
    parameter int NW = tmr16_pkg::N_WORDS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [AW-1:0]          addr,
    input  logic [BW-1:0]          wdata,
    input  logic [NW-1:0][2*BW-1:0] words,
    input  logic [BW-1:0]          ctrl_rd,
    input  logic [BW-1:0]          mask_rd,
    input  logic [BW-1:0]          flag_rd,
    output logic [NW-1:0]          word_we,
    output logic [2*BW-1:0]        word_data,
    output logic                   ctrl_we,
    output logic                   mask_we,
    output logic                   flag_we,
    output logic [BW-1:0]          rdata
);
    localparam int WW     = 2 * BW;
    localparam int IW     = $clog2(NW);
    localparam int SPAN   = 2 * NW;
    localparam int A_CTRL = SPAN;
    localparam int A_MASK = SPAN + 1;
    localparam int A_FLAG = SPAN + 2;

    logic          in_words;
    logic          hi_sel;
    logic [IW-1:0] idx;
    logic [BW-1:0] tmp_q;

    assign in_words = addr < AW'(SPAN);
    assign hi_sel   = addr[0];
    assign idx      = addr[IW:1];

    // shared upper-byte latch: write of a high byte fills it,
    // read of a low byte snapshots the register's high byte
    always_ff @(posedge clk) begin
        if (rst)
            tmp_q <= '0;
        else if (wr_en && in_words && hi_sel)
            tmp_q <= wdata;
        else if (rd_en && in_words && !hi_sel)
            tmp_q <= words[idx][WW-1:BW];
    end

    for (genvar g = 0; g < NW; g++) begin : g_we
        assign word_we[g] = wr_en && in_words && !hi_sel && (idx == IW'(g));
    end

    assign word_data = {tmp_q, wdata};
    assign ctrl_we   = wr_en && (addr == AW'(A_CTRL));
    assign mask_we   = wr_en && (addr == AW'(A_MASK));
    assign flag_we   = wr_en && (addr == AW'(A_FLAG));

    always_comb begin
        if (in_words)
            rdata = hi_sel ? tmp_q : words[idx][BW-1:0];
        else if (addr == AW'(A_CTRL))
            rdata = ctrl_rd;
        else if (addr == AW'(A_MASK))
            rdata = mask_rd;
        else if (addr == AW'(A_FLAG))
            rdata = flag_rd;
        else
            rdata = '0;
    end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
    parameter int W = tmr16_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         top_cap,
    input  logic [W-1:0] cap_val,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);
    logic [W-1:0] top;

    assign top  = top_cap ? cap_val : '1;
    assign wrap = run && !ld && (cnt_q == top);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (wrap)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/tmr16_compare.sv
module tmr16_compare #(
    parameter int W = tmr16_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         run,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cmp_q,
    output logic         hit
);
    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '0;
        else if (ld)
            cmp_q <= ld_val;
    end

    assign hit = run && (cnt == cmp_q);
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture #(
    parameter int W = tmr16_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin,
    input  logic         cmp_in,
    input  logic         sel_cmp,
    input  logic [W-1:0] cnt,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cap_q,
    output logic         evt
);
    logic trig;
    logic trig_q;

    assign trig = sel_cmp ? cmp_in : pin;
    assign evt  = trig && !trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            trig_q <= trig;
            if (evt)
                cap_q <= cnt;
            else if (ld)
                cap_q <= ld_val;
        end
    end
endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags #(
    parameter int BW = tmr16_pkg::BYTE_W,
    parameter logic [BW-1:0] IMPL = tmr16_pkg::FLAG_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] set_vec,
    input  logic          clr_we,
    input  logic          mask_we,
    input  logic [BW-1:0] wdata,
    input  logic          glb_ie,
    output logic [BW-1:0] flags_q,
    output logic [BW-1:0] mask_q,
    output logic          irq
);
    logic [BW-1:0] clr_vec;

    assign clr_vec = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= ((flags_q & ~clr_vec) | set_vec) & IMPL;
            if (mask_we)
                mask_q <= wdata & IMPL;
        end
    end

    assign irq = glb_ie && |(flags_q & mask_q);
endmodule

// File: rtl/timer16_bytebus.sv
module timer16_bytebus
    import tmr16_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          cap_pin,
    input  logic          cmp_in,
    input  logic          glb_ie,
    output logic          irq
);
    localparam int WW = 2 * BW;
    localparam int NW = N_WORDS;

    logic [NW-1:0][WW-1:0] words;
    logic [NW-1:0]         word_we;
    logic [WW-1:0]         word_data;
    logic                  ctrl_we, mask_we, flag_we;
    ctrl_t                 ctrl_q;
    logic [WW-1:0]         cnt_q;
    logic [WW-1:0]         cap_q;
    logic [N_CMP-1:0][WW-1:0] cmp_val;
    logic [N_CMP-1:0]      cmp_hit;
    logic                  wrap;
    logic                  cap_evt;
    logic [BW-1:0]         set_vec;
    logic [BW-1:0]         flags_q;
    logic [BW-1:0]         mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= byte_to_ctrl(bus_wdata);
    end

    always_comb begin
        words           = '0;
        words[SLOT_CNT] = cnt_q;
        words[SLOT_CAP] = cap_q;
        for (int c = 0; c < N_CMP; c++)
            words[SLOT_CMP + c] = cmp_val[c];
    end

    tmr16_bus #(.BW(BW), .AW(AW), .NW(NW)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .words    (words),
        .ctrl_rd  (ctrl_to_byte(ctrl_q)),
        .mask_rd  (mask_q),
        .flag_rd  (flags_q),
        .word_we  (word_we),
        .word_data(word_data),
        .ctrl_we  (ctrl_we),
        .mask_we  (mask_we),
        .flag_we  (flag_we),
        .rdata    (bus_rdata)
    );

    tmr16_counter #(.W(WW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.run),
        .top_cap(ctrl_q.top_cap),
        .cap_val(cap_q),
        .ld     (word_we[SLOT_CNT]),
        .ld_val (word_data),
        .cnt_q  (cnt_q),
        .wrap   (wrap)
    );

    for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
        tmr16_compare #(.W(WW)) u_cmp (
            .clk   (clk),
            .rst   (rst),
            .ld    (word_we[SLOT_CMP + c]),
            .ld_val(word_data),
            .run   (ctrl_q.run),
            .cnt   (cnt_q),
            .cmp_q (cmp_val[c]),
            .hit   (cmp_hit[c])
        );
    end

    tmr16_capture #(.W(WW)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .pin    (cap_pin),
        .cmp_in (cmp_in),
        .sel_cmp(ctrl_q.src_cmp),
        .cnt    (cnt_q),
        .ld     (word_we[SLOT_CAP]),
        .ld_val (word_data),
        .cap_q  (cap_q),
        .evt    (cap_evt)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[FB_OVF]  = wrap;
        set_vec[FB_CMPA] = cmp_hit[0];
        set_vec[FB_CMPB] = cmp_hit[1];
        set_vec[FB_CAP]  = cap_evt;
    end

    tmr16_flags #(.BW(BW), .IMPL(FLAG_BITS)) u_flg (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_vec),
        .clr_we (flag_we),
        .mask_we(mask_we),
        .wdata  (bus_wdata),
        .glb_ie (glb_ie),
        .flags_q(flags_q),
        .mask_q (mask_q),
        .irq    (irq)
    );
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  rdata,
    input logic        cap_pin,
    input logic        cmp_in,
    input logic        glb_ie,
    input logic        irq,
    input logic        run,
    input logic        top_cap,
    input logic        src_sel,
    input logic [15:0] cnt,
    input logic [15:0] cap,
    input logic [15:0] cmp_a,
    input logic [15:0] cmp_b,
    input logic [7:0]  flags,
    input logic [7:0]  mask
);
    logic        cnt_wr;
    logic        cap_wr;
    logic [15:0] top;

    assign cnt_wr = wr_en && (addr == 4'd0);
    assign cap_wr = wr_en && (addr == 4'd6);
    assign top    = top_cap ? cap : 16'hFFFF;

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !glb_ie |-> !irq);

    p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> |(flags & mask));

    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt));

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_wr && cnt != top) |=> (cnt == $past(cnt) + 16'd1));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_wr && cnt == top) |=> (cnt == 16'd0 && flags[0]));

    p_cmpa_r6: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == cmp_a) |=> flags[1]);

    p_cmpb_r6: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == cmp_b) |=> flags[2]);

    p_cap_pin_r7: assert property (@(posedge clk) disable iff (rst)
        (!src_sel && !$past(src_sel) && $rose(cap_pin))
        |=> (cap == $past(cnt) && flags[5]));

    p_cap_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (src_sel && $past(src_sel) && !$rose(cmp_in) && !cap_wr)
        |=> $stable(cap));

    p_hi_read_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 4'd1 && $past(rd_en && addr == 4'd0) && !$past(wr_en))
        |-> (rdata == $past(cnt[15:8])));
endmodule

bind timer16_bytebus tmr16_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .rdata  (bus_rdata),
    .cap_pin(cap_pin),
    .cmp_in (cmp_in),
    .glb_ie (glb_ie),
    .irq    (irq),
    .run    (ctrl_q.run),
    .top_cap(ctrl_q.top_cap),
    .src_sel(ctrl_q.src_cmp),
    .cnt    (cnt_q),
    .cap    (cap_q),
    .cmp_a  (cmp_val[0]),
    .cmp_b  (cmp_val[1]),
    .flags  (flags_q),
    .mask   (mask_q)
);

// File: tb/sim_timer16_bytebus.sv
module sim_timer16_bytebus;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       cmp_in = 1'b0;
    logic       glb_ie = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    timer16_bytebus u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .cmp_in(cmp_in), .glb_ie(glb_ie), .irq(irq)
    );

    localparam logic [3:0] A_CNT = 4'd0, A_CMPA = 4'd2, A_CMPB = 4'd4,
                           A_CAP = 4'd6, A_CTRL = 4'd8, A_MASK = 4'd9,
                           A_FLAG = 4'd10;

    // expected count after a run window: start + idle cycles + 1
    function automatic logic [15:0] exp_run(input logic [15:0] start, input int idle);
        return start + 16'(idle + 1);
    endfunction

    function automatic logic [7:0] exp_mask(input logic [7:0] v);
        return v & 8'h27;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        wr(a + 4'd1, v[15:8]);
        wr(a, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 4'd1, hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        void'($urandom(32'd1337));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd16(A_CNT, v);  check("R1 counter", v, 16'h0);
        rd16(A_CMPA, v); check("R1 compare A", v, 16'h0);
        rd16(A_CMPB, v); check("R1 compare B", v, 16'h0);
        rd16(A_CAP, v);  check("R1 capture", v, 16'h0);
        rd(A_CTRL, b);   check("R1 control", 16'(b), 16'h0);
        rd(A_MASK, b);   check("R1 mask", 16'(b), 16'h0);
        rd(A_FLAG, b);   check("R1 flags", 16'(b), 16'h0);
        check("R1 irq", 16'(irq), 16'h0);

        // R2/R3 random round trips through the shared latch (counter stopped)
        for (int i = 0; i < 12; i++) begin
            logic [3:0]  a;
            logic [15:0] val;
            a   = 4'(2 * ($urandom % 3));
            val = 16'($urandom);
            wr16(a, val);
            rd16(a, v);
            check("R2 R3 random round trip", v, val);
        end

        // R2 shared latch: high byte of A, low byte of B
        wr16(A_CMPA, 16'h1111);
        wr(A_CMPA + 4'd1, 8'hAB);
        wr(A_CMPB, 8'hCD);
        rd16(A_CMPB, v); check("R2 latch shared across registers", v, 16'hABCD);
        rd16(A_CMPA, v); check("R2 high write alone has no effect", v, 16'h1111);

        // R3 unmapped address
        rd(4'd13, b); check("R3 unmapped reads zero", 16'(b), 16'h0);

        // R3 snapshot while counting across a 256 boundary
        wr16(A_CNT, 16'h00F0);
        wr(A_CTRL, 8'h01);
        rd(A_CNT, b);
        repeat (40) @(negedge clk);
        rd(A_CNT + 4'd1, b); check("R3 stale high byte from snapshot", 16'(b), 16'h00);
        rd16(A_CNT, v); check("R3 fresh read high byte", 16'(v[15:8]), 16'h01);
        wr(A_CTRL, 8'h00);

        // R4 exact count and hold
        wr16(A_CNT, 16'h0100);
        wr(A_CTRL, 8'h01);
        repeat (5) @(negedge clk);
        wr(A_CTRL, 8'h00);
        rd16(A_CNT, v); check("R4 run count", v, exp_run(16'h0100, 5));
        repeat (5) @(negedge clk);
        rd16(A_CNT, v); check("R4 hold when stopped", v, exp_run(16'h0100, 5));

        // R4 write wins over counting
        wr(A_CTRL, 8'h01);
        wr16(A_CNT, 16'h4000);
        wr(A_CTRL, 8'h00);
        rd16(A_CNT, v); check("R4 write priority", v, 16'h4001);

        // R5 natural overflow
        wr16(A_CMPA, 16'h1000);
        wr16(A_CMPB, 16'h1000);
        wr16(A_CNT, 16'hFFFE);
        wr(A_FLAG, 8'hFF);
        wr(A_CTRL, 8'h01);
        repeat (1) @(negedge clk);
        wr(A_CTRL, 8'h00);
        rd16(A_CNT, v); check("R5 wrap value", v, exp_run(16'hFFFE, 1));
        rd(A_FLAG, b);  check("R5 overflow flag", 16'(b), 16'h01);

        // R5 capture as TOP
        wr16(A_CAP, 16'h0005);
        wr16(A_CNT, 16'h0003);
        wr(A_FLAG, 8'hFF);
        wr(A_CTRL, 8'h05);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 8'h04);
        rd16(A_CNT, v); check("R5 TOP wrap count", v, 16'h0001);
        rd(A_FLAG, b);  check("R5 TOP overflow flag", 16'(b), 16'h01);
        wr(A_CTRL, 8'h00);

        // R6 compare match A only
        wr16(A_CMPA, 16'h0020);
        wr16(A_CMPB, 16'h0100);
        wr16(A_CNT, 16'h001C);
        wr(A_FLAG, 8'hFF);
        wr(A_CTRL, 8'h01);
        repeat (6) @(negedge clk);
        wr(A_CTRL, 8'h00);
        rd16(A_CNT, v); check("R6 count after window", v, exp_run(16'h001C, 6));
        rd(A_FLAG, b);  check("R6 only compare A flag", 16'(b), 16'h02);

        // R9 write-one-to-clear
        wr(A_FLAG, 8'h04);
        rd(A_FLAG, b); check("R9 zero write keeps flag", 16'(b), 16'h02);
        wr(A_FLAG, 8'h02);
        rd(A_FLAG, b); check("R9 one write clears flag", 16'(b), 16'h00);

        // R9 set beats clear in the same cycle
        wr16(A_CMPA, 16'h0050);
        wr16(A_CNT, 16'h0050);
        wr(A_FLAG, 8'hFF);
        wr(A_CTRL, 8'h01);
        wr(A_FLAG, 8'h02);
        wr(A_CTRL, 8'h00);
        rd(A_FLAG, b); check("R9 event wins over clear", 16'(b & 8'h02), 16'h02);

        // R7 capture from pin (counter stopped)
        wr16(A_CNT, 16'h1234);
        wr(A_FLAG, 8'hFF);
        cap_pin = 1'b1;
        @(negedge clk);
        cap_pin = 1'b0;
        rd16(A_CAP, v); check("R7 pin capture value", v, 16'h1234);
        rd(A_FLAG, b);  check("R7 capture flag", 16'(b), 16'h20);

        // R8 comparator ignored while pin selected
        wr(A_FLAG, 8'hFF);
        wr16(A_CNT, 16'h2222);
        cmp_in = 1'b1;
        @(negedge clk);
        cmp_in = 1'b0;
        rd16(A_CAP, v); check("R8 unselected comparator ignored", v, 16'h1234);
        rd(A_FLAG, b);  check("R8 no capture flag", 16'(b), 16'h00);

        // R7 comparator selected
        wr(A_CTRL, 8'h02);
        cmp_in = 1'b1;
        @(negedge clk);
        cmp_in = 1'b0;
        rd16(A_CAP, v); check("R7 comparator capture", v, 16'h2222);

        // R8 pin ignored while comparator selected
        wr16(A_CNT, 16'h3333);
        cap_pin = 1'b1;
        @(negedge clk);
        cap_pin = 1'b0;
        rd16(A_CAP, v); check("R8 unselected pin ignored", v, 16'h2222);

        // R10 mask reserved bits
        wr(A_MASK, 8'hFF);
        rd(A_MASK, b); check("R10 mask readback", 16'(b), 16'(exp_mask(8'hFF)));

        // R11 interrupt gating (capture flag 5 is set)
        glb_ie = 1'b0;
        #1 check("R11 irq off without global enable", 16'(irq), 16'h0);
        @(negedge clk);
        glb_ie = 1'b1;
        #1 check("R11 irq on", 16'(irq), 16'h1);
        @(negedge clk);
        wr(A_MASK, 8'h07);
        check("R11 irq off when masked", 16'(irq), 16'h0);
        wr(A_MASK, 8'h27);
        wr(A_FLAG, 8'hFF);
        check("R11 irq off with no flags", 16'(irq), 16'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule